// File: doc/BRIEF.md
# I2C DAC Code Register

This block is an I2C target that holds the 10-bit code for a current-output converter. It runs entirely on the system clock. SCL and SDA pass through synchronizers, and the block watches their edges to find bus conditions and clock pulses. SDA is driven only as an open-drain pull-down enable. The stored code is presented on a parallel output that feeds the converter.

The block answers one 7-bit address, and the two lowest address bits do not matter. A write sends two data bytes. The low two bits of the first byte become the top of the code, and the second byte supplies the lower eight bits. The new code takes effect only once the second byte has been acknowledged. A read returns the code as two bytes in the same layout. Once both read bytes have gone out, the stored code is cleared to zero.

Top module: `i2c_dac_code_reg`

## Requirements
- R1: A START (SDA falling while SCL is high) begins a new address phase. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released.
- R2: The address byte is shifted in MSB first on SCL rising edges, and its last bit is R/W (0 = write, 1 = read). The address matches when bits [7:3] of the byte equal 00011, so write bytes 0x18/0x1A/0x1C/0x1E and read bytes 0x19/0x1B/0x1D/0x1F are all accepted. Any other address gets no acknowledge.
- R3: After a matching address byte and after each of the two write data bytes, the block pulls SDA low during the SCL low period before the ninth pulse. It keeps SDA low through the whole ninth high period.
- R4: A write loads code[9:8] from bits [1:0] of the first data byte and ignores bits [7:2]. It loads code[7:0] from the second data byte. code_o changes only after the ninth pulse of the second data byte has ended.
- R5: A write that stops after the first data byte leaves code_o unchanged.
- R6: A read sends first the byte {6'b0, code[9:8]} and then code[7:0], each MSB first. The block changes SDA only while SCL is low.
- R7: Once both read bytes have been clocked out, including the master's acknowledge slot, code_o becomes zero. If the master does not acknowledge the first read byte, SDA is released and code_o is kept.
- R8: After a non-matching address, SDA stays released for the rest of the transfer. A repeated START restarts address matching from the first bit.
- R9: After reset, code_o is zero and SDA is released.
- R10: A data byte after the second one in a write gets no acknowledge and does not change code_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| code_o | output | 10 | Stored converter code |

## Verification
Faults in this block show up at the ports in three ways:
- A wrong bit count or a wrong address decision shows up within one SCL period. The acknowledge slot then carries the wrong level, or SDA moves while SCL is high.
- A wrong byte-index or commit state corrupts code_o at the end of a transfer. The value is then too early, partial or mixed, and the bench sees it on the very next system clock after its short settle window.
- A faulty clear after a read is seen as a non-zero code as soon as that read ends.

The bench compares code_o with its reference on every clock and samples SDA twice in every high phase.

// File: rtl/i2c_dac_pkg.sv
package i2c_dac_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } tgt_state_e;

endpackage

// File: rtl/i2c_dac_sync.sv
module i2c_dac_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign dout[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/i2c_dac_bus_cond.sv
module i2c_dac_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    line_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign scl_rise  = scl_s & ~prev_q.scl;
    assign scl_fall  = ~scl_s & prev_q.scl;
    assign start_det = scl_s & prev_q.scl & prev_q.sda & ~sda_s;
    assign stop_det  = scl_s & prev_q.scl & ~prev_q.sda & sda_s;

endmodule

// File: rtl/i2c_dac_engine.sv
module i2c_dac_engine
    import i2c_dac_pkg::*;
#(
    parameter int          CODE_W    = 10,
    parameter logic [6:0]  DEV_ADDR  = 7'b0001100,
    parameter logic [6:0]  ADDR_MASK = 7'b1111100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_oe_o,
    output logic [CODE_W-1:0] code_o
);

    localparam int HI_W  = CODE_W - BYTE_W;
    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        tgt_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              rw;
        logic              idx;
        logic [HI_W-1:0]   hi;
        logic [CODE_W-1:0] code;
        logic              oe;
        logic              mack;
    } eng_t;

    eng_t d, q;

    logic              hit;
    logic [BYTE_W-1:0] hi_byte;

    assign hit     = ((q.sh[BYTE_W-1:1] ^ DEV_ADDR) & ADDR_MASK) == '0;
    assign hi_byte = {{(BYTE_W-HI_W){1'b0}}, q.code[CODE_W-1:BYTE_W]};

    always_comb begin
        d = q;
        if (start_det) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.idx = 1'b0;
            d.oe  = 1'b0;
        end else if (stop_det) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
            d.idx = 1'b0;
            d.oe  = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise && (q.cnt < CNT_FULL)) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && (q.cnt == CNT_FULL)) begin
                        d.cnt = '0;
                        if (q.st == ST_ADDR) begin
                            if (hit) begin
                                d.oe = 1'b1;
                                d.rw = q.sh[0];
                                d.st = ST_AACK;
                            end else begin
                                d.st = ST_SKIP;
                            end
                        end else begin
                            d.oe = 1'b1;
                            d.st = ST_WACK;
                            if (!q.idx) d.hi = q.sh[HI_W-1:0];
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        d.idx = 1'b0;
                        d.cnt = '0;
                        if (q.rw) begin
                            d.sh = hi_byte;
                            d.oe = ~hi_byte[BYTE_W-1];
                            d.st = ST_RDATA;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_WDATA;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        if (!q.idx) begin
                            d.idx = 1'b1;
                            d.st  = ST_WDATA;
                        end else begin
                            d.code = {q.hi, q.sh};
                            d.st   = ST_SKIP;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (q.cnt == CNT_LAST) begin
                            d.oe  = 1'b0;
                            d.cnt = '0;
                            d.st  = ST_RACK;
                        end else begin
                            d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe  = ~q.sh[BYTE_W-2];
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.idx) begin
                            d.code = '0;
                            d.st   = ST_SKIP;
                        end else if (q.mack) begin
                            d.idx = 1'b1;
                            d.sh  = q.code[BYTE_W-1:0];
                            d.oe  = ~q.code[BYTE_W-1];
                            d.st  = ST_RDATA;
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe_o = q.oe;
    assign code_o   = q.code;

endmodule

// File: rtl/i2c_dac_code_reg.sv
module i2c_dac_code_reg #(
    parameter int         CODE_W      = 10,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'b0001100,
    parameter logic [6:0] ADDR_MASK   = 7'b1111100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [CODE_W-1:0] code_o
);

    localparam int LINES = 2;

    logic [LINES-1:0] lines_s;
    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;

    i2c_dac_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    i2c_dac_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_dac_engine #(
        .CODE_W    (CODE_W),
        .DEV_ADDR  (DEV_ADDR),
        .ADDR_MASK (ADDR_MASK)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe_o  (sda_oe_o),
        .code_o    (code_o)
    );

endmodule

// File: rtl/i2c_dac_code_reg_chk.sv
module i2c_dac_code_reg_chk #(
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              scl_fall,
    input logic              start_det,
    input logic              stop_det,
    input logic              sda_oe,
    input logic [CODE_W-1:0] code
);

    // R6: the pull-down enable only moves while synchronized SCL is low
    p_sda_moves_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R4 / R5: the stored code only moves right after an SCL falling edge
    p_code_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code) |-> $past(scl_fall));

    // R1: a STOP leaves SDA released
    p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R8: a START or repeated START leaves SDA released
    p_start_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

endmodule

bind i2c_dac_code_reg i2c_dac_code_reg_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe_o),
    .code      (code_o)
);

// File: tb/i2c_dac_code_reg_test.sv
module i2c_dac_code_reg_test;

    localparam int H = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [9:0] code;
    wire        sda_bus = sda_m & ~sda_oe;

    int   checks = 0;
    int   fails = 0;
    int   printed = 0;
    bit   blank = 1'b1;
    bit   done = 1'b0;
    logic [9:0] exp_code = '0;

    always #10 clk = ~clk;

    i2c_dac_code_reg uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe),
        .code_o   (code)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle reference comparison of the code register
    always @(negedge clk) begin
        if (rst_n && !blank && !done) begin
            checks++;
            if (code !== exp_code) begin
                fails++;
                if (printed < 5) begin
                    printed++;
                    $display("FAIL R4 R5 R7 code model actual=0x%0h expected=0x%0h", code, exp_code);
                end
            end
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle_to(input logic [9:0] v);
        blank = 1'b1;
        wait_clks(8);
        exp_code = v;
        blank = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b0; wait_clks(H);
        scl_m = 1'b0; wait_clks(H / 2);
    endtask

    task automatic bus_restart();
        wait_clks(2);
        sda_m = 1'b1; wait_clks(H);
        scl_m = 1'b1; wait_clks(H);
        sda_m = 1'b0; wait_clks(H);
        scl_m = 1'b0; wait_clks(H / 2);
    endtask

    task automatic bus_stop();
        wait_clks(2);
        sda_m = 1'b0; wait_clks(H);
        scl_m = 1'b1; wait_clks(H);
        sda_m = 1'b1; wait_clks(H);
    endtask

    task automatic clock_bit(input logic b, output logic s, output logic stable);
        logic s1, s2;
        wait_clks(2);
        sda_m = b; wait_clks(H);
        scl_m = 1'b1; wait_clks(H / 4);
        s1 = sda_bus; wait_clks(H / 2);
        s2 = sda_bus; wait_clks(H / 4);
        scl_m = 1'b0;
        s = s1;
        stable = (s1 == s2);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack, output logic stable);
        logic s, st;
        stable = 1'b1;
        for (int i = 7; i >= 0; i--) clock_bit(v[i], s, st);
        clock_bit(1'b1, s, st);
        ack = ~s;
        stable = st;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] v, output logic stable);
        logic s, st;
        stable = 1'b1;
        v = '0;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s, st);
            v = {v[6:0], s};
            stable &= st;
        end
        clock_bit(~mack, s, st);
    endtask

    logic       ack, stab;
    logic [7:0] rb;

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        wait_clks(5);
        chk(code == 10'h0, "R9 reset code", int'(code), 0);
        chk(sda_oe == 1'b0, "R9 reset sda released", int'(sda_oe), 0);
        rst_n = 1'b1;
        wait_clks(5);
        blank = 1'b0;

        // R4: full write through base address, upper bits of first byte ignored
        bus_start();
        write_byte(8'h18, ack, stab);
        chk(ack, "R2 R3 addr 0x18 ack", int'(ack), 1);
        write_byte(8'hFE, ack, stab);
        chk(ack, "R3 first data ack", int'(ack), 1);
        chk(stab, "R3 ack held through high", int'(stab), 1);
        write_byte(8'h5A, ack, stab);
        chk(ack, "R3 second data ack", int'(ack), 1);
        settle_to(10'h25A);
        bus_stop();
        wait_clks(4);
        chk(sda_oe == 1'b0, "R1 stop releases sda", int'(sda_oe), 0);
        chk(code == 10'h25A, "R4 write commit", int'(code), 'h25A);

        // R2: masked address 0x1E
        bus_start();
        write_byte(8'h1E, ack, stab);
        chk(ack, "R2 addr 0x1E ack", int'(ack), 1);
        write_byte(8'h01, ack, stab);
        write_byte(8'h33, ack, stab);
        settle_to(10'h133);
        bus_stop();

        // R5: partial write via 0x1A
        bus_start();
        write_byte(8'h1A, ack, stab);
        chk(ack, "R2 addr 0x1A ack", int'(ack), 1);
        write_byte(8'h03, ack, stab);
        bus_stop();
        wait_clks(8);
        chk(code == 10'h133, "R5 partial write keeps code", int'(code), 'h133);

        // R8: mismatched address ignored, then repeated START with 0x1C
        bus_start();
        write_byte(8'h30, ack, stab);
        chk(!ack, "R2 R8 mismatch no ack", int'(ack), 0);
        write_byte(8'h00, ack, stab);
        chk(!ack, "R8 ignored data no ack", int'(ack), 0);
        bus_restart();
        write_byte(8'h1C, ack, stab);
        chk(ack, "R8 repeated start addr 0x1C ack", int'(ack), 1);
        write_byte(8'h00, ack, stab);
        write_byte(8'h07, ack, stab);
        settle_to(10'h007);
        bus_stop();
        chk(code == 10'h007, "R8 write after restart", int'(code), 'h007);

        // R10: third data byte not acknowledged
        bus_start();
        write_byte(8'h18, ack, stab);
        write_byte(8'h02, ack, stab);
        write_byte(8'hC3, ack, stab);
        settle_to(10'h2C3);
        write_byte(8'h11, ack, stab);
        chk(!ack, "R10 third byte no ack", int'(ack), 0);
        bus_stop();
        chk(code == 10'h2C3, "R10 code unchanged by third byte", int'(code), 'h2C3);

        // R6 R7: full read, then clear
        bus_start();
        write_byte(8'h19, ack, stab);
        chk(ack, "R2 read addr 0x19 ack", int'(ack), 1);
        read_byte(1'b1, rb, stab);
        chk(rb == 8'h02, "R6 read first byte", int'(rb), 'h02);
        chk(stab, "R6 sda stable in high", int'(stab), 1);
        read_byte(1'b0, rb, stab);
        chk(rb == 8'hC3, "R6 read second byte", int'(rb), 'hC3);
        chk(stab, "R6 sda stable in high second", int'(stab), 1);
        settle_to(10'h000);
        bus_stop();
        chk(code == 10'h000, "R7 read clears code", int'(code), 0);

        // R7: NACK after first read byte keeps code
        bus_start();
        write_byte(8'h18, ack, stab);
        write_byte(8'h01, ack, stab);
        write_byte(8'hFF, ack, stab);
        settle_to(10'h1FF);
        bus_stop();
        bus_start();
        write_byte(8'h1D, ack, stab);
        chk(ack, "R2 read addr 0x1D ack", int'(ack), 1);
        read_byte(1'b0, rb, stab);
        chk(rb == 8'h01, "R6 partial read byte", int'(rb), 'h01);
        wait_clks(4);
        chk(sda_oe == 1'b0, "R7 nack releases sda", int'(sda_oe), 0);
        bus_stop();
        chk(code == 10'h1FF, "R7 incomplete read keeps code", int'(code), 'h1FF);

        bus_start();
        write_byte(8'h1F, ack, stab);
        chk(ack, "R2 read addr 0x1F ack", int'(ack), 1);
        read_byte(1'b1, rb, stab);
        chk(rb == 8'h01, "R6 read hi 0x1F", int'(rb), 'h01);
        read_byte(1'b0, rb, stab);
        chk(rb == 8'hFF, "R6 read lo 0x1F", int'(rb), 'hFF);
        settle_to(10'h000);
        bus_stop();
        chk(code == 10'h000, "R7 second clear", int'(code), 0);

        wait_clks(10);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule